// File: doc/BRIEF.md
# Sectored Write-Back Cache Controller

This block is a direct-mapped, write-back cache that sits between a processor-side word port and a burst-capable memory port. Every line holds sixteen 64-bit words (128 bytes) and is split into a lower and an upper half of eight words. Each half has its own dirty flag. Allocation and invalidation always act on the whole line, but an eviction writes back only the halves that were modified.

A miss stalls the processor port. The controller first writes back the victim's dirty halves, lower half before upper half. It then requests the whole new line as one burst. That burst starts at the requested word and wraps around inside the line. On a read miss the requested word goes to the processor as soon as its beat arrives. On a write miss the store is merged into the line once the fill has finished.

Top module: `sector_cache`

## Requirements
- R1: After reset the port is idle with `cpu_ready` high, and every line is invalid and clean. The first access to any line misses and causes no write-back.
- R2: A read hit returns the stored word with `cpu_rvalid` high two cycles after the request is accepted. It issues no memory command.
- R3: A write hit updates the word and sets the dirty flag of its half. It finishes two cycles after acceptance with no memory command. Later reads return the new value.
- R4: A miss issues exactly one read command whose address is the requested word address. The address layout is tag | index | offset, and the half is selected by the offset MSB. Sixteen beats follow, and beat k fills line word (start offset + k) mod 16.
- R5: On a read miss, `cpu_rvalid` pulses once, in the cycle after the first fill beat is sampled, and carries that beat's data.
- R6: `cpu_ready` stays low from acceptance until the fill ends. It returns one cycle after the last beat for a read miss and two cycles after it for a write miss. The line becomes valid only with the last beat.
- R7: Each dirty half of a valid victim produces one write command at the half's base address, with the low three offset bits zero. Eight `mem_wvalid` beats in ascending word order follow, starting the cycle after the command is accepted.
- R8: When both halves are dirty, the lower half is written back first and the upper half next. Both finish before the fill command is issued.
- R9: A write miss fills the line first and then merges the store, which marks only that word's half dirty.
- R10: A clean victim, or the clean half of a victim, causes no write command or write beat.
- R11: `mem_cmd_valid`, `mem_cmd_we` and `mem_cmd_addr` hold steady until `mem_cmd_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request, taken when `cpu_ready` is high |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address of the request |
| cpu_wdata | input | WORD_W | Store data |
| cpu_ready | output | 1 | Controller idle and able to take a request |
| cpu_rvalid | output | 1 | Read data valid, one-cycle pulse |
| cpu_rdata | output | WORD_W | Read data |
| mem_cmd_valid | output | 1 | Memory command pending |
| mem_cmd_ready | input | 1 | Memory takes the command |
| mem_cmd_we | output | 1 | 1 = write-back of a half, 0 = line fill |
| mem_cmd_addr | output | ADDR_W | Word address of the first beat |
| mem_wvalid | output | 1 | Write-back beat valid |
| mem_wdata | output | WORD_W | Write-back beat data |
| mem_rvalid | input | 1 | Fill beat valid |
| mem_rdata | input | WORD_W | Fill beat data |

## Verification
The bench is built with 4 lines and a 10-bit address. Each pass over every line uses one of the four dirty-half patterns: none, lower only, upper only or both. The next conflicting miss therefore shows whether write-back is selective, whether the halves come out in the right order, and whether every write-back finishes before the fill.

Some misses start with a write and some with a read, and the critical word is placed at different offsets. This separates merge-after-fill from forwarding, and it tests the wrapped fill order against the alignment of the write-back address. The memory model leaves one gap in each fill burst and delays command acceptance. A final strided read sweep over the whole address space compares every result against the architectural memory image.

// File: rtl/sc_pkg.sv
package sc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_WB_CMD,
    ST_WB_DAT,
    ST_FILL_CMD,
    ST_FILL_DAT,
    ST_MERGE
  } sc_state_e;
endpackage

// File: rtl/sc_tag_store.sv
module sc_tag_store #(
  parameter int LINES = 8,
  parameter int TAG_W = 8,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] idx_i,
  output logic             rd_valid,
  output logic [1:0]       rd_dirty,
  output logic [TAG_W-1:0] rd_tag,
  input  logic             alloc_en,
  input  logic [TAG_W-1:0] alloc_tag,
  input  logic             set_valid_en,
  input  logic             set_dirty_en,
  input  logic             set_dirty_sec
);
  logic [LINES-1:0] vld_q;
  logic [1:0]       drt_q [LINES];
  logic [TAG_W-1:0] tag_q [LINES];

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
      for (int i = 0; i < LINES; i++) drt_q[i] <= 2'b00;
    end else begin
      if (alloc_en) begin
        vld_q[idx_i] <= 1'b0;
        drt_q[idx_i] <= 2'b00;
      end
      if (set_valid_en) vld_q[idx_i] <= 1'b1;
      if (set_dirty_en) drt_q[idx_i][set_dirty_sec] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_en) tag_q[idx_i] <= alloc_tag;
  end

  assign rd_valid = vld_q[idx_i];
  assign rd_dirty = drt_q[idx_i];
  assign rd_tag   = tag_q[idx_i];

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (vld_q == '0));

  // R6
  alloc_invalid_chk: assert property (@(posedge clk) disable iff (rst)
    alloc_en |=> (!vld_q[$past(idx_i)] && drt_q[$past(idx_i)] == 2'b00));

  // R9
  dirty_on_valid_chk: assert property (@(posedge clk) disable iff (rst)
    set_dirty_en |-> vld_q[idx_i]);
endmodule

// File: rtl/sc_data_ram.sv
module sc_data_ram #(
  parameter int DEPTH = 128,
  parameter int WIDTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/sector_cache.sv
module sector_cache
  import sc_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int WORD_W     = 64,
  parameter int LINE_WORDS = 16,
  parameter int LINES      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [WORD_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic              cpu_rvalid,
  output logic [WORD_W-1:0] cpu_rdata,
  output logic              mem_cmd_valid,
  input  logic              mem_cmd_ready,
  output logic              mem_cmd_we,
  output logic [ADDR_W-1:0] mem_cmd_addr,
  output logic              mem_wvalid,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_rvalid,
  input  logic [WORD_W-1:0] mem_rdata
);
  localparam int OFF_W  = $clog2(LINE_WORDS);
  localparam int HALF_W = OFF_W - 1;
  localparam int IDX_W  = $clog2(LINES);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int RAM_AW = IDX_W + OFF_W;

  sc_state_e st;
  logic [ADDR_W-1:0] req_addr;
  logic              req_we;
  logic [WORD_W-1:0] req_wdata;
  logic [OFF_W-1:0]  cnt;
  logic              wb_sec, wb_hi, rvalid_q;
  logic [WORD_W-1:0] rdata_q;

  wire [TAG_W-1:0] req_tag = req_addr[ADDR_W-1 -: TAG_W];
  wire [IDX_W-1:0] req_idx = req_addr[OFF_W +: IDX_W];
  wire [OFF_W-1:0] req_off = req_addr[OFF_W-1:0];
  wire             req_sec = req_off[OFF_W-1];

  logic             rd_valid;
  logic [1:0]       rd_dirty;
  logic [TAG_W-1:0] rd_tag;
  logic             alloc_en, set_valid_en, set_dirty_en;

  wire hit       = rd_valid && (rd_tag == req_tag);
  wire last_beat = (cnt == OFF_W'(LINE_WORDS - 1));
  wire [OFF_W-1:0]  fill_off = req_off + cnt;
  wire [HALF_W-1:0] wb_next  = cnt[HALF_W-1:0] + HALF_W'(1);

  logic              ram_we;
  logic [RAM_AW-1:0] ram_waddr, ram_raddr;
  logic [WORD_W-1:0] ram_wdata, ram_rdata;

  sc_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst(rst), .idx_i(req_idx),
    .rd_valid(rd_valid), .rd_dirty(rd_dirty), .rd_tag(rd_tag),
    .alloc_en(alloc_en), .alloc_tag(req_tag),
    .set_valid_en(set_valid_en), .set_dirty_en(set_dirty_en),
    .set_dirty_sec(req_sec)
  );

  sc_data_ram #(.DEPTH(LINES * LINE_WORDS), .WIDTH(WORD_W)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr(ram_raddr), .rdata(ram_rdata)
  );

  always_comb begin
    case (st)
      ST_IDLE:   ram_raddr = cpu_addr[RAM_AW-1:0];
      ST_WB_CMD: ram_raddr = {req_idx, wb_sec, HALF_W'(0)};
      ST_WB_DAT: ram_raddr = {req_idx, wb_sec, wb_next};
      default:   ram_raddr = {req_idx, req_off};
    endcase
    ram_we    = 1'b0;
    ram_waddr = {req_idx, req_off};
    ram_wdata = req_wdata;
    if (st == ST_LOOK && hit && req_we) ram_we = 1'b1;
    if (st == ST_MERGE) ram_we = 1'b1;
    if (st == ST_FILL_DAT && mem_rvalid) begin
      ram_we    = 1'b1;
      ram_waddr = {req_idx, fill_off};
      ram_wdata = mem_rdata;
    end
  end

  assign alloc_en     = (st == ST_FILL_CMD) && mem_cmd_ready;
  assign set_valid_en = (st == ST_FILL_DAT) && mem_rvalid && last_beat;
  assign set_dirty_en = (st == ST_LOOK && hit && req_we) || (st == ST_MERGE);

  assign mem_cmd_valid = (st == ST_WB_CMD) || (st == ST_FILL_CMD);
  assign mem_cmd_we    = (st == ST_WB_CMD);
  assign mem_cmd_addr  = (st == ST_WB_CMD) ? {rd_tag, req_idx, wb_sec, HALF_W'(0)} : req_addr;
  assign mem_wvalid    = (st == ST_WB_DAT);
  assign mem_wdata     = ram_rdata;
  assign cpu_ready     = (st == ST_IDLE);
  assign cpu_rvalid    = rvalid_q;
  assign cpu_rdata     = rdata_q;

  always_ff @(posedge clk) begin
    if (st == ST_IDLE && cpu_req) begin
      req_addr  <= cpu_addr;
      req_we    <= cpu_we;
      req_wdata <= cpu_wdata;
    end
    if (st == ST_LOOK && hit && !req_we) rdata_q <= ram_rdata;
    else if (st == ST_FILL_DAT && mem_rvalid && cnt == '0) rdata_q <= mem_rdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      wb_sec   <= 1'b0;
      wb_hi    <= 1'b0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= 1'b0;
      case (st)
        ST_IDLE: if (cpu_req) st <= ST_LOOK;
        ST_LOOK: begin
          if (hit) begin
            rvalid_q <= !req_we;
            st       <= ST_IDLE;
          end else if (rd_valid && rd_dirty[0]) begin
            wb_sec <= 1'b0;
            wb_hi  <= rd_dirty[1];
            st     <= ST_WB_CMD;
          end else if (rd_valid && rd_dirty[1]) begin
            wb_sec <= 1'b1;
            wb_hi  <= 1'b0;
            st     <= ST_WB_CMD;
          end else begin
            st <= ST_FILL_CMD;
          end
        end
        ST_WB_CMD: if (mem_cmd_ready) begin
          cnt <= '0;
          st  <= ST_WB_DAT;
        end
        ST_WB_DAT: begin
          cnt <= cnt + OFF_W'(1);
          if (cnt[HALF_W-1:0] == '1) begin
            if (wb_hi) begin
              wb_sec <= 1'b1;
              wb_hi  <= 1'b0;
              st     <= ST_WB_CMD;
            end else begin
              st <= ST_FILL_CMD;
            end
          end
        end
        ST_FILL_CMD: if (mem_cmd_ready) begin
          cnt <= '0;
          st  <= ST_FILL_DAT;
        end
        ST_FILL_DAT: if (mem_rvalid) begin
          cnt <= cnt + OFF_W'(1);
          if (cnt == '0 && !req_we) rvalid_q <= 1'b1;
          if (last_beat) st <= req_we ? ST_MERGE : ST_IDLE;
        end
        ST_MERGE: st <= ST_IDLE;
        default:  st <= ST_IDLE;
      endcase
    end
  end

  // R6
  accept_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && cpu_ready) |=> !cpu_ready);

  // R7
  wb_burst_start_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_cmd_valid && mem_cmd_ready && mem_cmd_we) |=> mem_wvalid);

  // R7
  wb_align_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_cmd_valid && mem_cmd_we) |-> (mem_cmd_addr[HALF_W-1:0] == '0));

  // R11
  cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_cmd_valid && !mem_cmd_ready) |=>
      (mem_cmd_valid && $stable(mem_cmd_addr) && $stable(mem_cmd_we)));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |-> (!mem_wvalid && !mem_cmd_valid));

  // R5
  single_resp_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_rvalid |=> !cpu_rvalid);
endmodule

// File: tb/tb_sector_cache.sv
module tb_sector_cache;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;
  localparam int WW = 64;
  localparam int LW = 16;
  localparam int NL = 4;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic          cpu_req = 1'b0, cpu_we = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [WW-1:0] cpu_wdata = '0;
  logic          cpu_ready, cpu_rvalid;
  logic [WW-1:0] cpu_rdata;
  logic          mem_cmd_valid, mem_cmd_we, mem_wvalid;
  logic          mem_cmd_ready = 1'b0, mem_rvalid = 1'b0;
  logic [AW-1:0] mem_cmd_addr;
  logic [WW-1:0] mem_wdata, mem_rdata = '0;

  sector_cache #(.ADDR_W(AW), .WORD_W(WW), .LINE_WORDS(LW), .LINES(NL)) dut (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rvalid(cpu_rvalid),
    .cpu_rdata(cpu_rdata), .mem_cmd_valid(mem_cmd_valid), .mem_cmd_ready(mem_cmd_ready),
    .mem_cmd_we(mem_cmd_we), .mem_cmd_addr(mem_cmd_addr), .mem_wvalid(mem_wvalid),
    .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [WW-1:0] mm [DEPTH];
  logic [WW-1:0] gm [DEPTH];
  int            ev_n = 0;
  logic [AW-1:0] ev_addr [8];
  logic          ev_we [8];
  int            beat0_cyc = 0, last_cyc = 0;

  bit          rvld [NL];
  logic [3:0]  rtag [NL];
  logic [1:0]  rdty [NL];
  int          wcnt = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // memory agent: one-cycle command wait, one gap per fill burst
  initial begin
    logic [AW-1:0] lat_addr, wa, ra;
    bit lat_we, rd_act, wr_act, gapped, wr_tail;
    int stage, rk, wk;
    lat_addr = '0; wa = '0; ra = '0; lat_we = 0;
    rd_act = 0; wr_act = 0; gapped = 0; wr_tail = 0;
    stage = 0; rk = 0; wk = 0;
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (wr_tail) begin
          chk(!mem_wvalid, "R7", "write beat count", 64'(mem_wvalid), 64'd0);
          wr_tail = 0;
        end
        if (mem_cmd_ready) begin
          mem_cmd_ready = 1'b0;
          if (ev_n < 8) begin
            ev_addr[ev_n] = lat_addr;
            ev_we[ev_n]   = lat_we;
          end
          ev_n++;
          if (lat_we) begin
            wr_act = 1; wa = lat_addr; wk = 0;
          end else begin
            rd_act = 1; ra = lat_addr; rk = 0; gapped = 0;
          end
          stage = 0;
        end else if (stage == 1) begin
          chk(mem_cmd_valid && mem_cmd_addr == lat_addr && mem_cmd_we == lat_we,
              "R11", "command held", 64'(mem_cmd_addr), 64'(lat_addr));
          mem_cmd_ready = 1'b1;
          stage = 2;
        end else if (stage == 0 && mem_cmd_valid && !rd_act && !wr_act) begin
          lat_addr = mem_cmd_addr;
          lat_we   = mem_cmd_we;
          stage    = 1;
        end
        if (wr_act) begin
          chk(mem_wvalid && mem_wdata == gm[wa + AW'(wk)], "R7", "write-back beat",
              mem_wdata, gm[wa + AW'(wk)]);
          mm[wa + AW'(wk)] = mem_wdata;
          wk++;
          if (wk == 8) begin
            wr_act = 0; wr_tail = 1;
          end
        end
        if (rd_act) begin
          if (rk == 5 && !gapped) begin
            mem_rvalid = 1'b0;
            gapped = 1;
          end else begin
            mem_rvalid = 1'b1;
            mem_rdata  = mm[{ra[AW-1:4], 4'(ra[3:0] + 4'(rk))}];
            if (rk == 0) beat0_cyc = cyc;
            if (rk == 15) begin
              last_cyc = cyc;
              rd_act = 0;
            end
            rk++;
          end
        end else begin
          mem_rvalid = 1'b0;
        end
      end
    end
  end

  task automatic access(input bit we, input logic [AW-1:0] a, input logic [WW-1:0] wd);
    logic [1:0] idx;
    logic [3:0] tg;
    bit hit;
    int exp_n, q, done_cyc, nrv, rv_cyc, guard;
    logic [AW-1:0] exp_addr [3];
    bit exp_we [3];
    logic [WW-1:0] rv_data;
    idx = a[5:4];
    tg  = a[9:6];
    hit = rvld[idx] && rtag[idx] == tg;
    exp_n = 0;
    if (!hit) begin
      for (int s = 0; s < 2; s++) begin
        if (rvld[idx] && rdty[idx][s]) begin
          exp_addr[exp_n] = {rtag[idx], idx, 1'(s), 3'b000};
          exp_we[exp_n]   = 1;
          exp_n++;
        end
      end
      exp_addr[exp_n] = a;
      exp_we[exp_n]   = 0;
      exp_n++;
    end
    ev_n = 0;
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    q = cyc;
    @(negedge clk);
    cpu_req = 1'b0;
    nrv = 0; rv_cyc = 0; rv_data = '0; guard = 0; done_cyc = 0;
    forever begin
      if (cpu_rvalid) begin
        nrv++;
        rv_cyc  = cyc;
        rv_data = cpu_rdata;
      end
      if (cpu_ready) begin
        done_cyc = cyc;
        break;
      end
      guard++;
      if (guard > 500) begin
        chk(0, "R6", "access never completed", 64'(guard), 64'd0);
        break;
      end
      @(negedge clk);
    end
    // memory traffic: R4 fill, R7/R8 write-back order, R10 clean halves silent, R3 hits silent
    chk(ev_n == exp_n, hit ? "R3" : "R10", "memory command count", 64'(ev_n), 64'(exp_n));
    if (ev_n == exp_n) begin
      for (int i = 0; i < exp_n; i++) begin
        chk(ev_addr[i] == exp_addr[i] && ev_we[i] == exp_we[i],
            exp_we[i] ? "R8" : "R4", "command address/order",
            {63'(ev_addr[i]), ev_we[i]}, {63'(exp_addr[i]), exp_we[i]});
      end
    end
    if (!we) begin
      chk(nrv == 1, hit ? "R2" : "R5", "response count", 64'(nrv), 64'd1);
      chk(rv_data == gm[a], hit ? "R2" : "R4", "read data", rv_data, gm[a]);
      if (!hit) chk(rv_cyc == beat0_cyc + 1, "R5", "forward timing",
                    64'(rv_cyc), 64'(beat0_cyc + 1));
    end else begin
      chk(nrv == 0, "R9", "no response on write", 64'(nrv), 64'd0);
    end
    if (hit)
      chk(done_cyc == q + 2, we ? "R3" : "R2", "hit latency", 64'(done_cyc), 64'(q + 2));
    else
      chk(done_cyc == last_cyc + (we ? 2 : 1), "R6", "ready after fill",
          64'(done_cyc), 64'(last_cyc + (we ? 2 : 1)));
    if (!hit) begin
      rvld[idx] = 1; rtag[idx] = tg; rdty[idx] = 2'b00;
    end
    if (we) begin
      rdty[idx][a[3]] = 1'b1;
      gm[a] = wd;
    end
  endtask

  function automatic logic [WW-1:0] wval(input int n, input logic [AW-1:0] a);
    return 64'hD000_0000_0000_0000 | (64'(n) << 16) | 64'(a);
  endfunction

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mm[i] = 64'h5A00_0000_0000_0000 | (64'(i) << 20) | 64'(i * 3 + 1);
      gm[i] = mm[i];
    end
    for (int i = 0; i < NL; i++) begin
      rvld[i] = 0; rtag[i] = '0; rdty[i] = 2'b00;
    end
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(cpu_ready == 1'b1, "R1", "ready after reset", 64'(cpu_ready), 64'd1);
    chk(!cpu_rvalid && !mem_cmd_valid && !mem_wvalid, "R1", "quiet after reset",
        {61'd0, cpu_rvalid, mem_cmd_valid, mem_wvalid}, 64'd0);
    // R1 first touch of every line: fill only
    for (int i = 0; i < NL; i++) access(0, AW'(i * 16 + i * 5), '0);
    // dirty-half patterns none/lower/upper/both, with write misses (R9)
    for (int t = 1; t <= 6; t++) begin
      for (int i = 0; i < NL; i++) begin
        int p, o;
        logic [AW-1:0] base;
        p = (t + i) % 4;
        o = (t * 5 + i * 3) % 16;
        base = {4'(t), 2'(i), 4'd0};
        wcnt++;
        if (t % 3 == 0) access(1, base + AW'(o), wval(wcnt, base + AW'(o)));
        else access(0, base + AW'(o), '0);
        if (p[0]) begin
          wcnt++;
          access(1, base + AW'((t + i) % 8), wval(wcnt, base + AW'((t + i) % 8)));
        end
        if (p[1]) begin
          wcnt++;
          access(1, base + AW'(8 + (t * 3) % 8), wval(wcnt, base + AW'(8 + (t * 3) % 8)));
        end
        access(0, base + AW'(o ^ 5), '0);
      end
    end
    // strided sweep over the whole address space
    for (int a = 0; a < DEPTH; a += 13) access(0, AW'(a), '0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R6 watchdog expired: actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule